// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a W-bit storage register whose next value is chosen each rising clock edge by a two-bit mode code. It can keep its contents, move them one position toward the least significant end, move them one position toward the most significant end, or replace them with a parallel word. Each shift direction has its own serial input, which supplies the bit that enters the vacated position.

Treated as an unsigned number with a zero serial input, a move toward the MSB doubles the value modulo 2^W, and a move toward the LSB halves it and drops the remainder. A synchronous active-low reset clears the register and overrides any mode. Mode, data and serial pins are plain levels sampled at the clock edge. There is no handshake: the register acts on every edge.

Top module: `univ_shift_reg`

## Requirements
- R1: If rst_n is low at a rising edge, q becomes all zeros after that edge, whatever the mode, par_in and serial inputs are.
- R2: With mode 2'b00 (hold), q keeps its value across the edge.
- R3: With mode 2'b01 (right shift), q becomes {shr_in, q[W-1:1]}: every bit moves one place toward bit 0, and shr_in enters bit W-1.
- R4: With mode 2'b10 (left shift), q becomes {q[W-2:0], shl_in}: every bit moves one place toward bit W-1, and shl_in enters bit 0.
- R5: With mode 2'b11 (load), q becomes par_in.
- R6: With a zero serial input, a left shift gives (q*2) mod 2^W and a right shift gives floor(q/2).
- R7: par_in affects q only in mode 2'b11, shl_in only in mode 2'b10, and shr_in only in mode 2'b01.
- R8: q changes only at a rising clock edge. It is constant between edges, even when the inputs change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low clear, overrides mode |
| mode | input | 2 | 00 hold, 01 right shift, 10 left shift, 11 load |
| par_in | input | W | Parallel word taken in load mode |
| shl_in | input | 1 | Bit entering bit 0 on a left shift |
| shr_in | input | 1 | Bit entering bit W-1 on a right shift |
| q | output | W | Register contents |

## Verification
The checker evaluates the reset-clear rule and the outcome of every mode at every edge: hold, the two shifts with their entering serial bits, and load. Because the mode-specific checks cover all four codes, an input that bleeds into a mode where it should be unused is also caught there. The arithmetic meaning of the shifts cannot be written as a property. It is shown by the bench's directed doubling and halving sequences. Stability between edges is shown only by the bench, which samples q at the falling edge after toggling inputs mid-cycle. Random mixes of all modes with reset pulses are compared against the behavioural model on every clock.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next_mux.sv
module usr_next_mux #(
  parameter int W = 4
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] par,
  input  logic         shl_in,
  input  logic         shr_in,
  output logic [W-1:0] nxt
);
  import usr_pkg::*;
  localparam int MSB = W - 1;

  usr_mode_e sel;
  assign sel = usr_mode_e'(mode);

  // Each output bit picks its own source; neighbours are wired per bit.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_hi, from_lo;
    if (i == MSB) begin : g_top
      assign from_hi = shr_in;
    end else begin : g_mid_hi
      assign from_hi = cur[i+1];
    end
    if (i == 0) begin : g_bot
      assign from_lo = shl_in;
    end else begin : g_mid_lo
      assign from_lo = cur[i-1];
    end

    always_comb begin
      unique case (sel)
        MODE_HOLD: nxt[i] = cur[i];
        MODE_SHR:  nxt[i] = from_hi;
        MODE_SHL:  nxt[i] = from_lo;
        MODE_LOAD: nxt[i] = par[i];
        default:   nxt[i] = cur[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_bit_cell.sv
module usr_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [W-1:0] par_in,
  input  logic         shl_in,
  input  logic         shr_in,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  usr_next_mux #(.W(W)) u_mux (
    .mode   (mode),
    .cur    (q),
    .par    (par_in),
    .shl_in (shl_in),
    .shr_in (shr_in),
    .nxt    (nxt)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    usr_bit_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nxt[i]),
      .q     (q[i])
    );
  end
endmodule

// File: rtl/usr_checker.sv
module usr_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic [W-1:0] par_in,
  input logic         shl_in,
  input logic         shr_in,
  input logic [W-1:0] q
);
  // Set once a reset edge has been seen, so that no check reads pre-reset X state.
  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (q == '0));

  a_r2_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (primed === 1'b1 && mode == 2'b00) |=> (q == $past(q)));

  a_r3_right_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (primed === 1'b1 && mode == 2'b01) |=>
      (q[W-1] == $past(shr_in) && q[W-2:0] == $past(q[W-1:1])));

  a_r4_left_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (primed === 1'b1 && mode == 2'b10) |=>
      (q[0] == $past(shl_in) && q[W-1:1] == $past(q[W-2:0])));

  a_r5_load_takes_word: assert property (@(posedge clk) disable iff (!rst_n)
    (primed === 1'b1 && mode == 2'b11) |=> (q == $past(par_in)));
endmodule

bind univ_shift_reg usr_checker #(.W(W)) u_usr_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode   (mode),
  .par_in (par_in),
  .shl_in (shl_in),
  .shr_in (shr_in),
  .q      (q)
);

// File: tb/univ_shift_reg_bench.sv
module univ_shift_reg_bench;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode;
  logic [W-1:0] par_in;
  logic         shl_in;
  logic         shr_in;
  logic [W-1:0] q;

  int checks = 0;
  int fails  = 0;
  int model;  // behavioural value of the register, as an unsigned integer
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  univ_shift_reg #(.W(W)) u_univ_shift_reg (
    .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(par_in),
    .shl_in(shl_in), .shr_in(shr_in), .q(q)
  );

  task automatic check(input string tag, input int expv);
    checks++;
    if (int'(q) !== expv) begin
      fails++;
      $display("FAIL %s: q=%0h expected %0h at %0t", tag, q, expv, $time);
    end
  endtask

  // Called at a falling edge: drive, predict, wait one cycle, compare.
  task automatic step(input logic rn, input logic [1:0] m, input int p,
                      input logic l, input logic r, input string tag);
    rst_n = rn; mode = m; par_in = W'(p); shl_in = l; shr_in = r;
    if (!rn) model = 0;
    else case (m)
      2'b00: model = model;
      2'b01: model = (model / 2) + (r ? (1 << (W-1)) : 0);
      2'b10: model = ((model * 2) + (l ? 1 : 0)) & MASK;
      default: model = p & MASK;
    endcase
    @(negedge clk);
    check(tag, model);
  endtask

  function automatic string mode_tag(input logic rn, input logic [1:0] m);
    if (!rn) return "R1";
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b11; par_in = '1; shl_in = 1'b1; shr_in = 1'b1;
    model = 0;
    @(negedge clk); @(negedge clk);
    check("R1 reset over load", 0);

    step(1, 2'b11, 4'hA, 0, 0, "R5 load A");
    step(1, 2'b00, 4'h5, 1, 1, "R2 hold with busy inputs");
    step(1, 2'b00, 4'h3, 0, 1, "R7 par_in ignored in hold");
    step(1, 2'b01, 4'hF, 1, 1, "R3 right shift msb gets 1");
    step(1, 2'b01, 4'hF, 1, 0, "R7 shl_in ignored on right shift");
    step(1, 2'b10, 4'h0, 1, 0, "R4 left shift lsb gets 1");
    step(1, 2'b10, 4'h0, 0, 1, "R7 shr_in ignored on left shift");

    step(1, 2'b11, 4'h3, 0, 0, "R5 load 3");
    step(1, 2'b10, 0, 0, 0, "R6 times two 3->6");
    step(1, 2'b10, 0, 0, 0, "R6 times two 6->C");
    step(1, 2'b10, 0, 0, 0, "R6 times two wraps C->8");
    step(1, 2'b11, 4'hF, 0, 0, "R5 load F");
    step(1, 2'b01, 0, 0, 0, "R6 halve F->7");
    step(1, 2'b01, 0, 0, 0, "R6 halve 7->3");
    step(1, 2'b01, 0, 0, 0, "R6 halve 3->1");
    step(1, 2'b01, 0, 0, 0, "R6 halve 1->0");

    step(1, 2'b11, 4'h9, 0, 0, "R5 load 9");
    step(0, 2'b11, 4'h6, 1, 1, "R1 reset overrides load");
    step(0, 2'b10, 4'h6, 1, 1, "R1 reset overrides shift");

    // R8: toggle inputs mid-cycle; q must not move until the next rising edge
    step(1, 2'b11, 4'h6, 0, 0, "R5 load 6");
    mode = 2'b11; par_in = 4'h1;
    #5;
    check("R8 stable after input change", model);
    par_in = 4'hE; shl_in = 1'b1; mode = 2'b10;
    #3;
    check("R8 stable before edge", model);
    mode = 2'b00; par_in = '0;
    @(negedge clk);
    check("R8 hold after late changes", model);

    for (int k = 0; k < 300; k++) begin
      logic rn;
      logic [1:0] m;
      rn = ($urandom % 16) != 0;
      m  = 2'($urandom);
      step(rn, m, int'($urandom % 16), 1'($urandom), 1'($urandom), mode_tag(rn, m));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule